// File: doc/BRIEF.md
# Bus Cycle Wait State Generator

This block holds a processor in its bus cycle for a chosen number of clocks. When a cycle begins, it looks at the kind of cycle being run and picks one of three wait counts. These are a count for the onboard ROM, a count for a selectable class of memory cycle, and a count for I/O port cycles. For that many clocks it pulls its ready output low, and then it releases the processor.

The count is kept in a thermometer shift chain. The chain loads when a cycle starts and shifts once per clock, and ready follows the bit at the end of the chain. The memory count is applied to interrupt-acknowledge cycles only, to opcode-fetch cycles only, or to every memory cycle, depending on a two-bit class selector. The block is placed between the cycle decoder and the processor's wait input.

Top module: `bus_wait_gen`

## Requirements
- R1: ready high means proceed and ready low means wait. If a cycle start is sampled on a rising edge with an effective count N from 1 to 8, ready is low for exactly the N clocks after that edge and then high again.
- R2: An effective count of zero leaves ready high for the whole cycle.
- R3: A 4-bit count setting above 8 inserts 8 waits.
- R4: When rom_sel is high at cycle start, rom_waits is used, even when the memory class or an I/O request also matches.
- R5: I/O cycles (iorq high, inta low) that are not ROM cycles use io_waits. An interrupt acknowledge never uses io_waits.
- R6: mem_class = 0 applies mem_waits to interrupt-acknowledge cycles (inta high) only. Plain memory and opcode-fetch cycles then get no waits.
- R7: mem_class = 1 applies mem_waits to opcode fetches (mreq and m1 high) only. Memory cycles with m1 low then get no waits.
- R8: mem_class = 2 or 3 applies mem_waits to every memory cycle (mreq high).
- R9: Count settings are taken only at cycle start. Changing them during the wait has no effect on that cycle.
- R10: A cycle that matches no class gets no waits. Ready never falls except on the edge that samples a cycle start.
- R11: While rst_n is low, ready is high and any count in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse marking the first clock of a bus cycle |
| rom_sel | input | 1 | Cycle addresses the onboard ROM |
| mreq | input | 1 | Memory request |
| m1 | input | 1 | Opcode fetch cycle |
| inta | input | 1 | Interrupt acknowledge cycle |
| iorq | input | 1 | I/O request |
| rom_waits | input | 4 | Wait count for ROM cycles |
| mem_waits | input | 4 | Wait count for the selected memory class |
| io_waits | input | 4 | Wait count for I/O cycles |
| mem_class | input | 2 | 0: INTA only, 1: opcode fetch only, 2/3: all memory |
| ready | output | 1 | High lets the processor proceed, low inserts a wait |

## Verification
The hardest case to reach is a change to the settings while a count is running. A correct design must ignore it, so nothing visible changes when it happens. The driver can rewrite all three counts on the clock after a cycle start, to zero or to a larger value. The scoreboard still expects the length chosen at the start. The reset case is reached the same way: the longest count is started and reset is pulled midway, and ready must come back at once with no leftover wait.

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int CNT_W     = 4,
  parameter int MAX_WAITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             rom_sel,
  input  logic             mreq,
  input  logic             m1,
  input  logic             inta,
  input  logic             iorq,
  input  logic [CNT_W-1:0] rom_waits,
  input  logic [CNT_W-1:0] mem_waits,
  input  logic [CNT_W-1:0] io_waits,
  input  logic [1:0]       mem_class,
  output logic             ready
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WAITS);

  logic                 hit_mem;
  logic [CNT_W-1:0]     pick, n;
  logic [MAX_WAITS-1:0] load_v, chain;

  always_comb begin
    case (mem_class)
      2'd0:    hit_mem = inta;
      2'd1:    hit_mem = mreq & m1;
      default: hit_mem = mreq;
    endcase
  end

  assign pick = rom_sel            ? rom_waits :
                hit_mem            ? mem_waits :
                (iorq & ~inta)     ? io_waits  : '0;
  assign n    = (pick > CAP) ? CAP : pick;

  for (genvar i = 0; i < MAX_WAITS; i++) begin : g_therm
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    assign load_v[i] = (n > IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chain <= '0;
    else if (cyc_start) chain <= load_v;
    else                chain <= {1'b0, chain[MAX_WAITS-1:1]};
  end

  assign ready = ~chain[0];
endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic       rom_sel,
  input logic       mreq,
  input logic       inta,
  input logic       iorq,
  input logic [3:0] rom_waits,
  input logic [3:0] io_waits,
  input logic       ready
);
  a_r2_rom_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && rom_sel && rom_waits == 4'd0 |=> ready);

  a_r4_rom_waits: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && rom_sel && rom_waits != 4'd0 |=> !ready);

  a_r5_io_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && !rom_sel && !mreq && !inta && iorq && io_waits == 4'd0 |=> ready);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !cyc_start |=> ready);

  always @(posedge clk)
    if (!rst_n) a_r11_reset_ready: assert (ready);
endmodule

bind bus_wait_gen bus_wait_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rom_sel(rom_sel),
  .mreq(mreq), .inta(inta), .iorq(iorq), .rom_waits(rom_waits),
  .io_waits(io_waits), .ready(ready)
);

// File: tb/sim_bus_wait_gen.sv
`timescale 1ns/1ps
module sim_bus_wait_gen;
  logic clk = 0, rst_n = 0;
  logic cyc_start = 0, rom_sel = 0, mreq = 0, m1 = 0, inta = 0, iorq = 0;
  logic [3:0] rom_waits = 0, mem_waits = 0, io_waits = 0;
  logic [1:0] mem_class = 0;
  logic ready;
  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bus_wait_gen u0 (.*);

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ready=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one bus cycle, n = expected waits, chg>=0 rewrites settings mid-wait
  task automatic cyc(input bit r, input bit mq, input bit f, input bit ia, input bit io,
                     input int rw, input int mw, input int iw, input int cls,
                     input int n, input string tag, input int chg = -1);
    @(negedge clk); #1;
    rom_sel = r; mreq = mq; m1 = f; inta = ia; iorq = io;
    rom_waits = 4'(rw); mem_waits = 4'(mw); io_waits = 4'(iw); mem_class = 2'(cls);
    cyc_start = 1;
    for (int i = 1; i <= n + 2; i++) begin
      exp_q.push_back(i > n);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk); #1;
      cyc_start = 0;
      if (chg >= 0) begin
        rom_waits = 4'(chg); mem_waits = 4'(chg); io_waits = 4'(chg);
      end
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (exp_q.size() != 0) chk(ready, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready, 1'b1, "R11 reset");
    rst_n = 1;
    @(negedge clk);
    chk(ready, 1'b1, "R10 idle after reset");

    cyc(0,1,1,0,0, 0,2,0, 1, 2, "R7 fetch");
    cyc(0,1,0,0,0, 0,6,0, 1, 0, "R7 non-fetch");
    cyc(1,1,1,0,1, 3,5,4, 2, 3, "R4 rom over mem");
    cyc(1,1,1,0,0, 0,5,0, 2, 0, "R2 rom zero");
    cyc(0,0,0,0,1, 0,0,4, 2, 4, "R5 io");
    cyc(0,0,0,0,1, 0,3,0, 2, 0, "R2 io zero");
    cyc(0,0,1,1,1, 0,6,2, 0, 6, "R6 inta");
    cyc(0,1,1,0,0, 0,6,0, 0, 0, "R6 fetch ignored");
    cyc(0,0,1,1,1, 0,6,2, 1, 0, "R5 inta no io wait");
    cyc(0,1,0,0,0, 0,1,0, 2, 1, "R8 class2");
    cyc(0,1,0,0,0, 0,7,0, 3, 7, "R8 class3");
    cyc(1,0,0,0,0, 15,0,0, 2, 8, "R3 clamp");
    cyc(0,0,0,0,1, 0,0,12, 2, 8, "R3 io clamp");
    cyc(0,0,0,0,0, 9,9,9, 2, 0, "R10 no class");
    cyc(0,0,0,0,1, 0,0,5, 2, 5, "R9 change to zero", 0);
    cyc(1,0,0,0,0, 1,0,0, 2, 1, "R9 change up", 9);
    for (int k = 1; k <= 8; k++) cyc(0,1,0,0,0, 0,k,0, 2, k, "R1 length");
    cyc(0,1,0,0,0, 0,3,0, 2, 3, "R1 back to back");

    @(negedge clk); #1;
    rom_sel = 1; rom_waits = 8; cyc_start = 1;
    @(negedge clk); #1; cyc_start = 0;
    chk(ready, 1'b0, "R1 before reset");
    @(negedge clk); #1; rst_n = 0;
    #2 chk(ready, 1'b1, "R11 reset clears");
    @(negedge clk); #1; rst_n = 1; rom_sel = 0;
    @(negedge clk);
    chk(ready, 1'b1, "R11 no leftover");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule